// File: doc/BRIEF.md
# External memory bank wait-state controller

This block sits between an internal bus master and an asynchronous external memory port. It accepts one access request at a time. The top bits of the 32-bit request address pick one of four memory banks, and the block drives that bank's select strobe. It then holds the read or write strobe for a length set per bank: a fixed number of wait states, an open-ended wait for the external acknowledge input, or a fixed count followed by a wait for acknowledge. When the access ends, the block sends a one-cycle ready pulse back to the master together with the read data it captured.

Each access also carries a page-hit flag for page-mode DRAM. The flag says that the access stays inside the same 1K-word row as the previous access. Address, write data and read data pass through registers and are not otherwise changed. Refresh, width packing and bus arbitration are handled elsewhere.

Top module: `xmem_wait_ctrl`

## Requirements
- R1: During an access, `mem_bank_sel` has exactly one bit set, bit n for address bits [31:30] == n. Outside an access it is all zero.
- R2: Mode code 0 (count) and code 3 (handled the same as 0) hold the strobe for exactly W+1 cycles, where W is the bank's wait count. `mem_ack` has no effect in these modes.
- R3: A request with `req_write`=1 drives `mem_wr`, and one with `req_write`=0 drives `mem_rd`. The two are never high together. `mem_addr` and `mem_wdata` carry the accepted request's values for the whole access.
- R4: `req_rdy` is high for exactly one cycle, the cycle right after the last strobe cycle. In that cycle `req_rdata` equals the `mem_rdata` value sampled at the clock edge that ended the access.
- R5: Mode code 1 (acknowledge) holds the strobe until `mem_ack` is seen high at a rising edge, for at least one cycle. The wait count is ignored.
- R6: Mode code 2 (count then acknowledge) holds the strobe for at least W+1 cycles and then until `mem_ack` is seen high at a rising edge. An acknowledge seen before the count has run out does not end the access early.
- R7: `mem_page_hit` is high during an access only when an earlier access has been accepted since reset and that access had the same address bits [31:10], which include the bank bits. It is low for the first access after reset.
- R8: A request is accepted at a rising edge only when `req_busy` is low, and the strobes start in the next cycle. `req_busy` stays high from that cycle through the ready cycle. Requests presented while busy are ignored, and the access in progress does not change.
- R9: While reset is active, all strobes, `req_rdy`, `req_busy` and `mem_page_hit` are low.
- R10: Bank n takes its wait count from `cfg_wait[3n+2:3n]` and its mode from `cfg_mode[2n+1:2n]`. Both are sampled when the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wait | input | 12 | Per-bank wait counts, 3 bits each |
| cfg_mode | input | 8 | Per-bank wait modes, 2 bits each |
| req_valid | input | 1 | Master request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Request address |
| req_wdata | input | 32 | Write data |
| req_busy | output | 1 | Access in progress |
| req_rdy | output | 1 | One-cycle completion pulse |
| req_rdata | output | 32 | Captured read data |
| mem_addr | output | 32 | External address |
| mem_wdata | output | 32 | External write data |
| mem_rdata | input | 32 | External read data |
| mem_ack | input | 1 | External acknowledge |
| mem_bank_sel | output | 4 | One-hot bank selects |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_page_hit | output | 1 | Access within the previous page |

## Verification
The bench targets the edges of the wait-length rules. It uses zero wait states, the largest count, an acknowledge that is already high in the first cycle, and an acknowledge that arrives before or after the count runs out in mode 2. A design that let an early acknowledge cut the count short, or that ignored the acknowledge in count mode incorrectly, would give the wrong strobe length. It also drives requests during a busy access; a design that accepted them would change `mem_addr` or start a second access without a gap. Page-hit checks cover the first access after reset, a bank change with the same low address bits, and a repeat of the same row. A design that compared the wrong address bits, or that kept history across reset, would flag the wrong accesses.

// File: rtl/xmw_pkg.sv
package xmw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_READY  = 2'd2
  } xmw_state_e;

  typedef enum logic [1:0] {
    WM_COUNT     = 2'd0,
    WM_ACK       = 2'd1,
    WM_COUNT_ACK = 2'd2,
    WM_RSVD      = 2'd3
  } xmw_mode_e;
endpackage

// File: rtl/xmw_bank_decode.sv
module xmw_bank_decode #(
  parameter int NBANK  = 4,
  parameter int BANK_W = $clog2(NBANK)
) (
  input  logic [BANK_W-1:0] idx,
  input  logic              en,
  output logic [NBANK-1:0]  sel
);
  for (genvar g = 0; g < NBANK; g++) begin : g_sel
    assign sel[g] = en && (idx == BANK_W'(g));
  end
endmodule

// File: rtl/xmw_page_track.sv
module xmw_page_track #(
  parameter int TAG_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [TAG_W-1:0] tag_in,
  output logic             hit
);
  logic             prev_v_q, prev_v_d;
  logic [TAG_W-1:0] prev_tag_q;
  logic             hit_q, hit_d;

  always_comb begin
    prev_v_d = prev_v_q | accept;
    hit_d    = prev_v_q && (prev_tag_q == tag_in);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_v_q   <= 1'b0;
      prev_tag_q <= '0;
      hit_q      <= 1'b0;
    end else if (accept) begin
      prev_v_q   <= prev_v_d;
      prev_tag_q <= tag_in;
      hit_q      <= hit_d;
    end
  end

  assign hit = hit_q;
endmodule

// File: rtl/xmw_seq.sv
module xmw_seq
  import xmw_pkg::*;
#(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WAIT_W-1:0] wait_val,
  input  logic [1:0]        mode_in,
  input  logic              ext_ack,
  output logic              idle,
  output logic              in_access,
  output logic              finish,
  output logic              ready
);
  xmw_state_e        st_q, st_d;
  xmw_mode_e         mode_q, mode_d;
  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic              cnt_zero, need_ack;

  assign cnt_zero = (cnt_q == '0);
  assign need_ack = (mode_q == WM_ACK) || (mode_q == WM_COUNT_ACK);

  always_comb begin
    st_d   = st_q;
    mode_d = mode_q;
    cnt_d  = cnt_q;
    finish = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d   = ST_ACCESS;
          mode_d = xmw_mode_e'(mode_in);
          cnt_d  = (xmw_mode_e'(mode_in) == WM_ACK) ? '0 : wait_val;
        end
      end
      ST_ACCESS: begin
        if (!cnt_zero) cnt_d = cnt_q - 1'b1;
        finish = cnt_zero && (!need_ack || ext_ack);
        if (finish) st_d = ST_READY;
      end
      ST_READY: st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      mode_q <= WM_COUNT;
      cnt_q  <= '0;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
    end
  end

  assign idle      = (st_q == ST_IDLE);
  assign in_access = (st_q == ST_ACCESS);
  assign ready     = (st_q == ST_READY);
endmodule

// File: rtl/xmem_wait_ctrl.sv
module xmem_wait_ctrl #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int NBANK    = 4,
  parameter int WAIT_W   = 3,
  parameter int PAGE_LSB = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NBANK*WAIT_W-1:0] cfg_wait,
  input  logic [NBANK*2-1:0]      cfg_mode,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [DATA_W-1:0]       req_wdata,
  output logic                    req_busy,
  output logic                    req_rdy,
  output logic [DATA_W-1:0]       req_rdata,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [DATA_W-1:0]       mem_wdata,
  input  logic [DATA_W-1:0]       mem_rdata,
  input  logic                    mem_ack,
  output logic [NBANK-1:0]        mem_bank_sel,
  output logic                    mem_rd,
  output logic                    mem_wr,
  output logic                    mem_page_hit
);
  localparam int BANK_W = $clog2(NBANK);
  localparam int TAG_W  = ADDR_W - PAGE_LSB;

  // reset: asynchronous assertion, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic              idle, in_access, finish, ready, accept;
  logic [BANK_W-1:0] req_bank;
  logic [WAIT_W-1:0] sel_wait;
  logic [1:0]        sel_mode;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              wr_q, page_hit_q;

  assign accept   = req_valid && idle;
  assign req_bank = req_addr[ADDR_W-1 -: BANK_W];
  assign sel_wait = cfg_wait[req_bank*WAIT_W +: WAIT_W];
  assign sel_mode = cfg_mode[req_bank*2 +: 2];

  xmw_seq #(.WAIT_W(WAIT_W)) seq_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (accept),
    .wait_val (sel_wait),
    .mode_in  (sel_mode),
    .ext_ack  (mem_ack),
    .idle     (idle),
    .in_access(in_access),
    .finish   (finish),
    .ready    (ready)
  );

  xmw_page_track #(.TAG_W(TAG_W)) page_i (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .accept(accept),
    .tag_in(req_addr[ADDR_W-1:PAGE_LSB]),
    .hit   (page_hit_q)
  );

  xmw_bank_decode #(.NBANK(NBANK)) dec_i (
    .idx(addr_q[ADDR_W-1 -: BANK_W]),
    .en (in_access),
    .sel(mem_bank_sel)
  );

  // request capture, enabled on accept
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      wr_q    <= req_write;
    end
  end

  // read data capture, enabled on the finishing edge
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rdata_q <= '0;
    else if (finish) rdata_q <= mem_rdata;
  end

  assign mem_addr     = addr_q;
  assign mem_wdata    = wdata_q;
  assign mem_rd       = in_access && !wr_q;
  assign mem_wr       = in_access && wr_q;
  assign mem_page_hit = in_access && page_hit_q;
  assign req_busy     = !idle;
  assign req_rdy      = ready;
  assign req_rdata    = rdata_q;
endmodule

// File: rtl/xmw_checker.sv
module xmw_checker #(
  parameter int ADDR_W = 32,
  parameter int NBANK  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [NBANK-1:0]  mem_bank_sel,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              req_rdy,
  input logic              req_busy,
  input logic              mem_page_hit
);
  logic strobe;
  assign strobe = mem_rd | mem_wr;

  AST_SEL_ONEHOT:   assert property (@(posedge clk) disable iff (!rst_n) $onehot0(mem_bank_sel)); // R1
  AST_SEL_STROBE:   assert property (@(posedge clk) disable iff (!rst_n) strobe |-> ($countones(mem_bank_sel) == 1)); // R1
  AST_RD_WR_EXCL:   assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr)); // R3
  AST_RDY_PULSE:    assert property (@(posedge clk) disable iff (!rst_n) req_rdy |=> !req_rdy); // R4
  AST_RDY_AFTER:    assert property (@(posedge clk) disable iff (!rst_n) $rose(req_rdy) |-> $past(strobe)); // R4
  AST_ADDR_STABLE:  assert property (@(posedge clk) disable iff (!rst_n) (strobe && $past(strobe)) |-> $stable(mem_addr)); // R8
  AST_SEL_STABLE:   assert property (@(posedge clk) disable iff (!rst_n) (strobe && $past(strobe)) |-> $stable(mem_bank_sel)); // R8
  AST_BUSY_STROBE:  assert property (@(posedge clk) disable iff (!rst_n) strobe |-> req_busy); // R8
  AST_PAGE_STROBE:  assert property (@(posedge clk) disable iff (!rst_n) mem_page_hit |-> strobe); // R7
endmodule

bind xmem_wait_ctrl xmw_checker #(.ADDR_W(ADDR_W), .NBANK(NBANK)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .mem_rd      (mem_rd),
  .mem_wr      (mem_wr),
  .mem_bank_sel(mem_bank_sel),
  .mem_addr    (mem_addr),
  .req_rdy     (req_rdy),
  .req_busy    (req_busy),
  .mem_page_hit(mem_page_hit)
);

// File: tb/xmem_wait_ctrl_tb.sv
module xmem_wait_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] cfg_wait = '0;
  logic [7:0]  cfg_mode = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0, mem_rdata = '0;
  logic        mem_ack = 1'b0;
  logic        req_busy, req_rdy, mem_rd, mem_wr, mem_page_hit;
  logic [31:0] req_rdata, mem_addr, mem_wdata;
  logic [3:0]  mem_bank_sel;

  int checks = 0, fails = 0;
  bit prev_v = 0;
  logic [31:0] prev_a = '0;
  bit done = 0;

  always #4 clk = ~clk;

  xmem_wait_ctrl dut_i (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_len(input int m, input int w, input int d);
    if (m == 1) return d + 1;
    if (m == 2) return ((w > d) ? w : d) + 1;
    return w + 1;
  endfunction

  task automatic set_bank(input int b, input int w, input int m);
    @(negedge clk);
    cfg_wait[b*3 +: 3] = 3'(w);
    cfg_mode[b*2 +: 2] = 2'(m);
  endtask

  task automatic run_access(input logic [31:0] a, input bit wr, input logic [31:0] wd,
                            input int d, input bit poke);
    int b, w, m, len, el;
    bit eph;
    logic [31:0] rv;
    b   = int'(a[31:30]);
    w   = int'(cfg_wait[b*3 +: 3]);
    m   = int'(cfg_mode[b*2 +: 2]);
    el  = exp_len(m, w, d);
    eph = prev_v && (prev_a[31:10] == a[31:10]);
    rv  = $urandom;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_wdata = wd;
    mem_rdata = rv; mem_ack = 1'b0;
    @(negedge clk);
    req_valid = poke;
    if (poke) begin req_addr = a ^ 32'h8000_0400; req_write = ~wr; end
    len = 0;
    while ((mem_rd | mem_wr) && len < 64) begin
      if (len == 0) begin
        chk(mem_bank_sel == 4'(1 << b), "R1 bank select", mem_bank_sel, 1 << b);
        chk(mem_wr == wr && mem_rd == !wr, "R3 strobe type", {mem_rd, mem_wr}, {!wr, wr});
        chk(mem_addr == a && (!wr || mem_wdata == wd), "R3 addr/wdata", mem_addr, a);
        chk(mem_page_hit == eph, "R7 page hit", mem_page_hit, eph);
        chk(req_busy == 1'b1, "R8 busy during access", req_busy, 1);
      end
      if (poke) chk(mem_addr == a, "R8 busy request ignored", mem_addr, a);
      mem_ack = (len >= d);
      len++;
      @(negedge clk);
    end
    if (m == 1) chk(len == el, "R5 ack mode length", len, el);
    else if (m == 2) chk(len == el, "R6 count+ack length", len, el);
    else chk(len == el, "R2 count mode length", len, el);
    chk(req_rdy == 1'b1, "R4 ready pulse", req_rdy, 1);
    if (!wr) chk(req_rdata == rv, "R4 read data", req_rdata, rv);
    req_valid = 1'b0; mem_ack = 1'b0;
    @(negedge clk);
    chk(!req_rdy && !mem_rd && !mem_wr && !req_busy, "R8 idle after ready",
        {req_rdy, mem_rd, mem_wr, req_busy}, 0);
    prev_v = 1; prev_a = a;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!mem_rd && !mem_wr && !req_rdy && !req_busy && !mem_page_hit && mem_bank_sel == 0,
        "R9 reset state", {mem_rd, mem_wr, req_rdy, req_busy, mem_page_hit}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // directed corners, R10 per-bank fields
    set_bank(0, 0, 0); set_bank(1, 7, 0); set_bank(2, 3, 1); set_bank(3, 2, 2);
    run_access(32'h0000_1234, 0, 32'h1, 0, 0);       // R7 first after reset: no hit; R2 W=0
    run_access(32'h0000_1300, 1, 32'hA5A5, 0, 0);    // R7 same row -> hit
    run_access(32'h4000_1300, 0, 32'h0, 0, 1);       // R2 W=7 ack early ignored; R8 poke; R1 bank1
    run_access(32'h8000_1300, 0, 32'h0, 0, 0);       // R5 ack at first cycle
    run_access(32'h8000_1304, 1, 32'h77, 6, 0);      // R5 late ack, count ignored
    run_access(32'hC000_0000, 0, 32'h0, 0, 0);       // R6 ack early, count rules
    run_access(32'hC000_0004, 0, 32'h0, 5, 1);       // R6 ack late
    set_bank(3, 7, 3);
    run_access(32'hC000_0008, 1, 32'h9, 2, 0);       // R2 reserved mode as count
    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      for (int bb = 0; bb < 4; bb++) set_bank(bb, $urandom_range(0, 7), $urandom_range(0, 3));
      a = $urandom;
      if ($urandom_range(0, 2) == 0) a = {prev_a[31:10], 10'($urandom)};
      run_access(a, 1'($urandom), $urandom, $urandom_range(0, 9), ($urandom_range(0, 4) == 0));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule